// File: doc/BRIEF.md
# Ingress Queue Priority Classifier

This block picks one of four egress priority queues for each frame that arrives on a switch port. A parser upstream supplies the frame's attributes: whether it carries a VLAN tag, the 3-bit PCP field from that tag, whether it is an IP frame, and its 6-bit DSCP field. The block also takes the port's configuration: an enable for tag-priority (802.1p) classification, an enable for DiffServ classification, and a 2-bit default queue for the port. It returns a 2-bit queue number with a valid strobe, one clock after the request.

Two small lookup tables translate a PCP value and a DSCP value into a queue number. Software fills them through a write-only address/data/strobe port. An enabled method succeeds only when the frame carries the field it reads. A success replaces the port default. When both methods succeed, the two queue numbers are merged by bitwise OR, not by a precedence rule. Frame parsing, queue storage and scheduling are handled outside this block.

Top module: `ingress_qclass`

## Requirements
- R1: After reset, out_vld is 0, out_queue is 0, and every entry of both lookup tables reads as queue 0.
- R2: out_vld is 1 in the cycle after a cycle with in_vld high, and 0 in the cycle after a cycle with in_vld low. A new request is accepted every cycle.
- R3: With both enables low, out_queue is port_dflt no matter what the frame's attributes are.
- R4: With only en_dot1p high, a tagged frame gets the PCP table entry indexed by in_pcp, even if that entry is 0. An untagged frame gets port_dflt.
- R5: With only en_dscp high, an IP frame (in_ip = 1) gets the DSCP table entry indexed by in_dscp. A non-IP frame gets port_dflt.
- R6: With both enables high, a tagged IP frame gets the bitwise OR of its PCP table entry and its DSCP table entry. port_dflt has no effect on this result.
- R7: With both enables high, a frame that satisfies only one method gets that method's entry on its own. A frame that satisfies neither gets port_dflt.
- R8: cfg_sel = 0 writes the PCP table at index cfg_addr[2:0], and the upper address bits are ignored. cfg_sel = 1 writes the DSCP table at index cfg_addr[5:0]. A write changes only the selected table. A lookup made in the same cycle as a write sees the old entry, and a lookup one cycle later sees the new entry.
- R9: While in_vld is low, out_queue keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Table write strobe |
| cfg_sel | input | 1 | Table select: 0 = PCP table, 1 = DSCP table |
| cfg_addr | input | 6 | Table write index |
| cfg_data | input | 2 | Queue number to store |
| en_dot1p | input | 1 | Port enable for tag-priority classification |
| en_dscp | input | 1 | Port enable for DiffServ classification |
| port_dflt | input | 2 | Port default queue |
| in_vld | input | 1 | Classification request strobe |
| in_tagged | input | 1 | Frame carries a VLAN tag |
| in_pcp | input | 3 | PCP field of the tag |
| in_ip | input | 1 | Frame is IPv4 or IPv6 |
| in_dscp | input | 6 | DSCP field of the IP header |
| out_vld | output | 1 | Result strobe |
| out_queue | output | 2 | Selected queue number |

## Verification
The bench builds the block with its default widths: a 3-bit PCP index and a 6-bit DSCP index. With those widths it can fill all 8 PCP entries and all 64 DSCP entries with a known pattern (PCP entry = low two index bits, DSCP entry = top two index bits). That pattern lets an OR result differ from each of its two inputs. The 6-bit write address together with the 3-bit PCP index also makes the ignored upper address bits reachable, so the bench can test address aliasing into the smaller table and isolation between the two tables.

// File: rtl/iqc_pkg.sv
package iqc_pkg;

    localparam int QW        = 2;
    localparam int PCP_BITS  = 3;
    localparam int DSCP_BITS = 6;

    typedef logic [QW-1:0] queue_t;

    typedef enum logic {
        TBL_PCP  = 1'b0,
        TBL_DSCP = 1'b1
    } tbl_sel_e;

    typedef struct packed {
        logic   hit_tag;
        logic   hit_ds;
        queue_t q_tag;
        queue_t q_ds;
        queue_t q_dflt;
    } cls_in_t;

    // Merge the two method results; default survives only when both miss.
    function automatic queue_t iqc_merge(input cls_in_t c);
        queue_t r;
        unique case ({c.hit_tag, c.hit_ds})
            2'b11:   r = c.q_tag | c.q_ds;
            2'b10:   r = c.q_tag;
            2'b01:   r = c.q_ds;
            default: r = c.q_dflt;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/iqc_map_table.sv
module iqc_map_table
    import iqc_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  queue_t           wdata,
    input  logic [IDX_W-1:0] raddr,
    output queue_t           rdata
);
    localparam int DEPTH = 1 << IDX_W;

    queue_t entry_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                entry_q[i] <= '0;
            end else if (we && (waddr == IDX_W'(i))) begin
                entry_q[i] <= wdata;
            end
        end
    end

    assign rdata = entry_q[raddr];

endmodule

// File: rtl/iqc_resolve.sv
module iqc_resolve
    import iqc_pkg::*;
(
    input  logic   en_tag,
    input  logic   en_ds,
    input  logic   is_tagged,
    input  logic   is_ip,
    input  queue_t q_tag,
    input  queue_t q_ds,
    input  queue_t q_dflt,
    output queue_t q_sel
);
    cls_in_t c;

    always_comb begin
        c.hit_tag = en_tag && is_tagged;
        c.hit_ds  = en_ds && is_ip;
        c.q_tag   = q_tag;
        c.q_ds    = q_ds;
        c.q_dflt  = q_dflt;
        q_sel     = iqc_merge(c);
    end

endmodule

// File: rtl/iqc_out_stage.sv
module iqc_out_stage
    import iqc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   req,
    input  queue_t q_in,
    output logic   vld_o,
    output queue_t q_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o <= 1'b0;
            q_o   <= '0;
        end else begin
            vld_o <= req;
            if (req) begin
                q_o <= q_in;
            end
        end
    end

endmodule

// File: rtl/ingress_qclass.sv
module ingress_qclass
    import iqc_pkg::*;
#(
    parameter  int PCP_W  = PCP_BITS,
    parameter  int DSCP_W = DSCP_BITS,
    localparam int AW     = (PCP_W > DSCP_W) ? PCP_W : DSCP_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [AW-1:0]     cfg_addr,
    input  logic [QW-1:0]     cfg_data,
    input  logic              en_dot1p,
    input  logic              en_dscp,
    input  logic [QW-1:0]     port_dflt,
    input  logic              in_vld,
    input  logic              in_tagged,
    input  logic [PCP_W-1:0]  in_pcp,
    input  logic              in_ip,
    input  logic [DSCP_W-1:0] in_dscp,
    output logic              out_vld,
    output logic [QW-1:0]     out_queue
);
    tbl_sel_e sel;
    logic     we_pcp;
    logic     we_dscp;
    queue_t   q_pcp;
    queue_t   q_dscp;
    queue_t   q_next;

    assign sel     = tbl_sel_e'(cfg_sel);
    assign we_pcp  = cfg_we && (sel == TBL_PCP);
    assign we_dscp = cfg_we && (sel == TBL_DSCP);

    iqc_map_table #(.IDX_W(PCP_W)) u_pcp_tbl (
        .clk   (clk),
        .rst   (rst),
        .we    (we_pcp),
        .waddr (cfg_addr[PCP_W-1:0]),
        .wdata (cfg_data),
        .raddr (in_pcp),
        .rdata (q_pcp)
    );

    iqc_map_table #(.IDX_W(DSCP_W)) u_dscp_tbl (
        .clk   (clk),
        .rst   (rst),
        .we    (we_dscp),
        .waddr (cfg_addr[DSCP_W-1:0]),
        .wdata (cfg_data),
        .raddr (in_dscp),
        .rdata (q_dscp)
    );

    iqc_resolve u_resolve (
        .en_tag    (en_dot1p),
        .en_ds     (en_dscp),
        .is_tagged (in_tagged),
        .is_ip     (in_ip),
        .q_tag     (q_pcp),
        .q_ds      (q_dscp),
        .q_dflt    (port_dflt),
        .q_sel     (q_next)
    );

    iqc_out_stage u_out (
        .clk   (clk),
        .rst   (rst),
        .req   (in_vld),
        .q_in  (q_next),
        .vld_o (out_vld),
        .q_o   (out_queue)
    );

endmodule

// File: rtl/iqc_checker.sv
module iqc_checker
    import iqc_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        en_dot1p,
    input logic        en_dscp,
    input logic [QW-1:0] port_dflt,
    input logic        in_vld,
    input logic        in_tagged,
    input logic        in_ip,
    input logic        out_vld,
    input logic [QW-1:0] out_queue
);
    // R2
    vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> out_vld);

    // R2
    vld_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> !out_vld);

    // R9
    queue_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> $stable(out_queue));

    // R3
    no_method_dflt_chk: assert property (@(posedge clk) disable iff (rst)
        (in_vld && !en_dot1p && !en_dscp) |=> (out_queue == $past(port_dflt)));

    // R4
    untagged_dflt_chk: assert property (@(posedge clk) disable iff (rst)
        (in_vld && en_dot1p && !en_dscp && !in_tagged) |=> (out_queue == $past(port_dflt)));

    // R5
    non_ip_dflt_chk: assert property (@(posedge clk) disable iff (rst)
        (in_vld && !en_dot1p && en_dscp && !in_ip) |=> (out_queue == $past(port_dflt)));

    // R7
    both_miss_dflt_chk: assert property (@(posedge clk) disable iff (rst)
        (in_vld && en_dot1p && en_dscp && !in_tagged && !in_ip) |=> (out_queue == $past(port_dflt)));

endmodule

bind ingress_qclass iqc_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .en_dot1p  (en_dot1p),
    .en_dscp   (en_dscp),
    .port_dflt (port_dflt),
    .in_vld    (in_vld),
    .in_tagged (in_tagged),
    .in_ip     (in_ip),
    .out_vld   (out_vld),
    .out_queue (out_queue)
);

// File: tb/ingress_qclass_tb_top.sv
module ingress_qclass_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       cfg_we, cfg_sel;
    logic [5:0] cfg_addr;
    logic [1:0] cfg_data;
    logic       en_dot1p, en_dscp;
    logic [1:0] port_dflt;
    logic       in_vld, in_tagged, in_ip;
    logic [2:0] in_pcp;
    logic [5:0] in_dscp;
    logic       out_vld;
    logic [1:0] out_queue;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    ingress_qclass dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_addr(cfg_addr), .cfg_data(cfg_data), .en_dot1p(en_dot1p),
        .en_dscp(en_dscp), .port_dflt(port_dflt), .in_vld(in_vld),
        .in_tagged(in_tagged), .in_pcp(in_pcp), .in_ip(in_ip),
        .in_dscp(in_dscp), .out_vld(out_vld), .out_queue(out_queue)
    );

    // {rid[4], en_dot1p, en_dscp, tagged, pcp[3], ip, dscp[6], dflt[2], exp[2]}
    // Tables: pcp entry = pcp[1:0], dscp entry = dscp[5:4]
    localparam logic [20:0] VEC [12] = '{
        {4'd3, 1'b0, 1'b0, 1'b1, 3'd3, 1'b1, 6'd48, 2'd2, 2'd2}, // R3
        {4'd4, 1'b1, 1'b0, 1'b1, 3'd1, 1'b0, 6'd0,  2'd2, 2'd1}, // R4 tagged
        {4'd4, 1'b1, 1'b0, 1'b0, 3'd3, 1'b1, 6'd48, 2'd2, 2'd2}, // R4 untagged
        {4'd5, 1'b0, 1'b1, 1'b1, 3'd3, 1'b1, 6'd32, 2'd1, 2'd2}, // R5 ip
        {4'd5, 1'b0, 1'b1, 1'b1, 3'd3, 1'b0, 6'd48, 2'd1, 2'd1}, // R5 non-ip
        {4'd6, 1'b1, 1'b1, 1'b1, 3'd1, 1'b1, 6'd32, 2'd0, 2'd3}, // R6 1|2
        {4'd6, 1'b1, 1'b1, 1'b1, 3'd6, 1'b1, 6'd0,  2'd3, 2'd2}, // R6 2|0 beats dflt
        {4'd7, 1'b1, 1'b1, 1'b1, 3'd1, 1'b0, 6'd48, 2'd2, 2'd1}, // R7 tag only
        {4'd7, 1'b1, 1'b1, 1'b0, 3'd3, 1'b1, 6'd16, 2'd2, 2'd1}, // R7 ip only
        {4'd7, 1'b1, 1'b1, 1'b0, 3'd3, 1'b0, 6'd63, 2'd3, 2'd3}, // R7 neither
        {4'd4, 1'b1, 1'b0, 1'b1, 3'd4, 1'b0, 6'd0,  2'd3, 2'd0}, // R4 zero entry
        {4'd3, 1'b0, 1'b0, 1'b0, 3'd7, 1'b0, 6'd21, 2'd1, 2'd1}  // R3
    };

    task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tbl_wr(input logic sel, input logic [5:0] a, input logic [1:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_addr = a; cfg_data = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Request issued at a negedge, result sampled at the following negedge.
    task automatic classify(input logic e1, input logic e2, input logic tg,
                            input logic [2:0] p, input logic ip,
                            input logic [5:0] d, input logic [1:0] dflt);
        @(negedge clk);
        en_dot1p = e1; en_dscp = e2; in_tagged = tg; in_pcp = p;
        in_ip = ip; in_dscp = d; port_dflt = dflt; in_vld = 1'b1;
        @(negedge clk);
        in_vld = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hang expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cfg_we = 1'b0; cfg_sel = 1'b0; cfg_addr = '0; cfg_data = '0;
        en_dot1p = 1'b0; en_dscp = 1'b0; port_dflt = '0; in_vld = 1'b0;
        in_tagged = 1'b0; in_pcp = '0; in_ip = 1'b0; in_dscp = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset outputs
        chk("R1 out_vld", {1'b0, out_vld}, 2'd0);
        chk("R1 out_queue", out_queue, 2'd0);
        // R1 tables cleared: both hit, 0|0 overrides default 3
        classify(1'b1, 1'b1, 1'b1, 3'd5, 1'b1, 6'd40, 2'd3);
        chk("R1 zero tables", out_queue, 2'd0);
        chk("R2 vld after req", {1'b0, out_vld}, 2'd1);

        for (int p = 0; p < 8; p++) tbl_wr(1'b0, 6'(p), 2'(p));
        for (int d = 0; d < 64; d++) tbl_wr(1'b1, 6'(d), 2'(d >> 4));

        for (int i = 0; i < 12; i++) begin
            classify(VEC[i][16], VEC[i][15], VEC[i][14], VEC[i][13:11],
                     VEC[i][10], VEC[i][9:4], VEC[i][3:2]);
            chk($sformatf("R%0d vector %0d", VEC[i][20:17], i), out_queue, VEC[i][1:0]);
        end

        // R2 back-to-back requests, one per cycle
        @(negedge clk);
        en_dot1p = 1'b1; en_dscp = 1'b0; in_tagged = 1'b1; in_pcp = 3'd1; in_vld = 1'b1;
        @(negedge clk);
        chk("R2 burst first", out_queue, 2'd1);
        in_pcp = 3'd2;
        @(negedge clk);
        chk("R2 burst second", out_queue, 2'd2);
        chk("R2 burst vld", {1'b0, out_vld}, 2'd1);
        in_vld = 1'b0; in_pcp = 3'd3;
        @(negedge clk);
        chk("R2 idle vld", {1'b0, out_vld}, 2'd0);
        // R9 hold while idle, inputs changed
        chk("R9 hold", out_queue, 2'd2);
        @(negedge clk);
        chk("R9 hold later", out_queue, 2'd2);

        // R8 write and lookup in the same cycle: old entry seen
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 1'b1; cfg_addr = 6'd5; cfg_data = 2'd3;
        en_dot1p = 1'b0; en_dscp = 1'b1; in_ip = 1'b1; in_dscp = 6'd5;
        port_dflt = 2'd1; in_vld = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0; in_vld = 1'b0;
        chk("R8 same-cycle old", out_queue, 2'd0);
        classify(1'b0, 1'b1, 1'b0, 3'd0, 1'b1, 6'd5, 2'd1);
        chk("R8 new entry", out_queue, 2'd3);
        // R8 upper address bits ignored for PCP table
        tbl_wr(1'b0, 6'd58, 2'd1);
        classify(1'b1, 1'b0, 1'b1, 3'd2, 1'b0, 6'd0, 2'd0);
        chk("R8 pcp alias", out_queue, 2'd1);
        // R8 dscp table untouched by pcp write
        classify(1'b0, 1'b1, 1'b0, 3'd0, 1'b1, 6'd58, 2'd0);
        chk("R8 dscp isolated", out_queue, 2'd3);

        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule